// File: doc/BRIEF.md
# Linear CCD readout timing sequencer

This block drives a 3000-pixel linear CCD sensor whose clock drivers sit on the sensor itself. It divides the system clock into a pixel clock and issues a transfer-gate pulse to start each line. That pulse moves the integrated charge into the sensor's shift register. The block can also issue a purge pulse that drops the charge gathered so far, which shortens the integration time without changing the line period. Next to the drive pins it reports which element the sensor is presenting: an index that restarts on every line, and a two-bit segment tag for downstream sampling logic.

Each line carries 3066 elements. These are 24 dummies, 30 optical-black elements, 2 more dummies, 3000 effective pixels and 10 trailing dummies. The sensor needs at least 3100 pixel-clock pulses between transfer pulses, so the programmed line length is clamped to that floor. Any pulses past element 3065 are tagged as trailing dummy. The half-period of the pixel clock is clamped so that the pixel rate stays between 100 kHz and 1 MHz for the system clock given by `CLK_HZ`.

The controller is a three-state machine:
- `ST_IDLE`: the pixel clock is held high and the transfer gate is low.
- `ST_XFER`: the transfer gate is high for `XFER_HALVES` half-periods and the pixel clock is held high.
- `ST_SHIFT`: the pixel clock toggles.

The transitions are:
- start: `ST_IDLE` to `ST_XFER` when `run` is high.
- gate done: `ST_XFER` to `ST_SHIFT`.
- repeat: `ST_SHIFT` to `ST_XFER` at line end while `run` is high.
- stop: `ST_SHIFT` to `ST_IDLE` at line end while `run` is low.

Top module: `ccd_line_sequencer`

## Requirements
- R1: The pixel clock half-period, in system clocks, is `div_half` clamped to [HALF_MIN, HALF_MAX], where HALF_MIN = ceil(CLK_HZ/2 MHz) and HALF_MAX = floor(CLK_HZ/200 kHz).
- R2: `xfer` stays high for exactly XFER_HALVES half-periods. `pix_clk` is high throughout that time and falls for the first time one half-period after `xfer` falls.
- R3: Between a falling edge of `xfer` and the end of that line there are exactly max(`line_len`, 3100) falling edges of `pix_clk`.
- R4: Each falling edge of `pix_clk` starts one element. At that edge `elem_idx` takes the element's number, which is 0 for the first element after the transfer pulse and rises by one per element.
- R5: `elem_seg` encodes the element class as follows: 0 for leading dummies (index 0–23 and 54–55), 1 for optical black (24–53), 2 for effective pixels (56–3055) and 3 for trailing dummies (3056 and above).
- R6: `elem_valid` is high for exactly one system cycle, in the cycle in which `pix_clk` rises within a line. It is never high at any other time.
- R7: `line_start` is high for exactly one cycle, in the cycle in which `xfer` rises.
- R8: When `purge_en` is set at line start, `purge` is high for the whole of element number `purge_dly` and low at all other times. When `purge_en` is clear, `purge` stays low.
- R9: After reset, or when `run` is low at line end, the outputs rest with `pix_clk` high and `xfer`, `purge` and `line_start` low. A rise of `run` then starts a line at once.
- R10: `div_half`, `line_len`, `purge_en` and `purge_dly` are sampled as the transfer pulse begins. Changing them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep producing lines while high |
| div_half | input | DIV_W | Requested pixel-clock half-period in system clocks |
| line_len | input | LINE_W | Requested pixel-clock pulses per line |
| purge_en | input | 1 | Enable the purge pulse |
| purge_dly | input | LINE_W | Element number during which the purge pulse is high |
| pix_clk | output | 1 | Pixel clock to the sensor |
| xfer | output | 1 | Transfer-gate pulse to the sensor |
| purge | output | 1 | Charge-purge (electronic shutter) pulse to the sensor |
| line_start | output | 1 | One-cycle strobe at the start of each transfer pulse |
| elem_valid | output | 1 | One-cycle sampling strobe per element |
| elem_idx | output | LINE_W | Number of the current element |
| elem_seg | output | 2 | Segment tag of the current element |

## Verification
Some properties are checked on every cycle. These are:
- The divider count stays below the latched half-period.
- `pix_clk` is held high under the transfer pulse.
- `line_start` coincides with the rise of `xfer`, and `elem_valid` with a rise of `pix_clk`.
- `purge` is never high outside an armed line or during a transfer pulse.
- Indices past the line layout carry the trailing tag.
- The element counter never passes the latched line length.

Other behaviour only shows in the bench's scenarios, which run whole lines at both clamp limits of the divider and check the tag at every index. Those scenarios cover:
- The exact pulse count per line.
- The segment boundaries.
- Where the purge pulse falls.
- The fact that settings changed in mid-line leave that line unchanged.
- The idle state after a stop.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [1:0] {
        SEG_LEAD = 2'd0,
        SEG_OB   = 2'd1,
        SEG_EFF  = 2'd2,
        SEG_TAIL = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ccd_clk_div.sv
module ccd_clk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == half - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the phase count never reaches the half-period it divides by
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < half));

endmodule

// File: rtl/ccd_seg_decode.sv
module ccd_seg_decode
    import ccd_seq_pkg::*;
#(
    parameter int LINE_W = 13,
    parameter int N_LEAD = 24,
    parameter int N_OB   = 30,
    parameter int N_GAP  = 2,
    parameter int N_EFF  = 3000
) (
    input  logic [LINE_W-1:0] idx,
    output seg_e              seg
);

    localparam int B_OB  = N_LEAD;
    localparam int B_GAP = B_OB + N_OB;
    localparam int B_EFF = B_GAP + N_GAP;
    localparam int B_TL  = B_EFF + N_EFF;

    always_comb begin
        if (idx < LINE_W'(B_OB))       seg = SEG_LEAD;
        else if (idx < LINE_W'(B_GAP)) seg = SEG_OB;
        else if (idx < LINE_W'(B_EFF)) seg = SEG_LEAD;
        else if (idx < LINE_W'(B_TL))  seg = SEG_EFF;
        else                           seg = SEG_TAIL;
    end

endmodule

// File: rtl/ccd_purge_gen.sv
module ccd_purge_gen #(
    parameter int LINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_evt,
    input  logic              line_end,
    input  logic              arm_en,
    input  logic [LINE_W-1:0] dly,
    input  logic [LINE_W-1:0] next_idx,
    output logic              purge
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            purge <= 1'b0;
        end else if (line_end) begin
            purge <= 1'b0;
        end else if (fall_evt) begin
            purge <= arm_en && (next_idx == dly);
        end
    end

    // R8: a purge pulse only exists in a line that armed it
    assert_purge_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        purge |-> arm_en);

endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
    import ccd_seq_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int PIX_MIN_HZ  = 100_000,
    parameter int PIX_MAX_HZ  = 1_000_000,
    parameter int DIV_W       = 16,
    parameter int LINE_W      = 13,
    parameter int MIN_LINE    = 3100,
    parameter int XFER_HALVES = 4,
    parameter int N_LEAD      = 24,
    parameter int N_OB        = 30,
    parameter int N_GAP       = 2,
    parameter int N_EFF       = 3000,
    parameter int N_TAIL      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  div_half,
    input  logic [LINE_W-1:0] line_len,
    input  logic              purge_en,
    input  logic [LINE_W-1:0] purge_dly,
    output logic              pix_clk,
    output logic              xfer,
    output logic              purge,
    output logic              line_start,
    output logic              elem_valid,
    output logic [LINE_W-1:0] elem_idx,
    output logic [1:0]        elem_seg
);

    localparam int HALF_MIN   = (CLK_HZ + 2 * PIX_MAX_HZ - 1) / (2 * PIX_MAX_HZ);
    localparam int HALF_MAX   = CLK_HZ / (2 * PIX_MIN_HZ);
    localparam int LAYOUT_LEN = N_LEAD + N_OB + N_GAP + N_EFF + N_TAIL;
    localparam int XC_W       = $clog2(XFER_HALVES + 1);

    seq_state_e        state_q, state_d;
    logic [DIV_W-1:0]  half_c, half_q;
    logic [LINE_W-1:0] len_c, len_q, dly_q, pcnt;
    logic              arm_q, tick, load;
    logic              fall_evt, rise_evt, end_evt, xfer_done;
    logic [XC_W-1:0]   xcnt;
    seg_e              seg;

    // setting clamps
    always_comb begin
        if (div_half < DIV_W'(HALF_MIN))      half_c = DIV_W'(HALF_MIN);
        else if (div_half > DIV_W'(HALF_MAX)) half_c = DIV_W'(HALF_MAX);
        else                                  half_c = div_half;
        len_c = (line_len < LINE_W'(MIN_LINE)) ? LINE_W'(MIN_LINE) : line_len;
    end

    ccd_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q != ST_IDLE),
        .half  (half_q),
        .tick  (tick)
    );

    assign fall_evt  = (state_q == ST_SHIFT) && tick && pix_clk;
    assign rise_evt  = (state_q == ST_SHIFT) && tick && !pix_clk;
    assign end_evt   = rise_evt && (pcnt == len_q);
    assign xfer_done = (state_q == ST_XFER) && tick && (xcnt == XC_W'(XFER_HALVES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run)       state_d = ST_XFER;
            ST_XFER:  if (xfer_done) state_d = ST_SHIFT;
            ST_SHIFT: if (end_evt)   state_d = run ? ST_XFER : ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    assign load = (state_d == ST_XFER) && (state_q != ST_XFER);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and line datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_clk    <= 1'b1;
            xfer       <= 1'b0;
            line_start <= 1'b0;
            elem_valid <= 1'b0;
            elem_idx   <= '0;
            pcnt       <= '0;
            xcnt       <= '0;
            half_q     <= DIV_W'(HALF_MIN);
            len_q      <= LINE_W'(MIN_LINE);
            arm_q      <= 1'b0;
            dly_q      <= '0;
        end else begin
            xfer       <= (state_d == ST_XFER);
            line_start <= load;
            elem_valid <= rise_evt;
            if (load) begin
                half_q <= half_c;
                len_q  <= len_c;
                arm_q  <= purge_en;
                dly_q  <= purge_dly;
                xcnt   <= '0;
                pcnt   <= '0;
            end else if ((state_q == ST_XFER) && tick) begin
                xcnt <= xcnt + 1'b1;
            end
            if (fall_evt) begin
                pix_clk  <= 1'b0;
                elem_idx <= pcnt;
                pcnt     <= pcnt + 1'b1;
            end else if (rise_evt) begin
                pix_clk <= 1'b1;
            end
        end
    end

    ccd_purge_gen #(.LINE_W(LINE_W)) u_purge (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_evt (fall_evt),
        .line_end (end_evt),
        .arm_en   (arm_q),
        .dly      (dly_q),
        .next_idx (pcnt),
        .purge    (purge)
    );

    ccd_seg_decode #(
        .LINE_W (LINE_W),
        .N_LEAD (N_LEAD),
        .N_OB   (N_OB),
        .N_GAP  (N_GAP),
        .N_EFF  (N_EFF)
    ) u_seg (
        .idx (elem_idx),
        .seg (seg)
    );

    assign elem_seg = seg;

    assert_pix_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> pix_clk);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (pcnt <= len_q));

    assert_tail_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_idx >= LINE_W'(LAYOUT_LEN)) |-> (elem_seg == SEG_TAIL));

    assert_valid_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> (pix_clk && !$past(pix_clk)));

    assert_start_on_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (xfer && !$past(xfer)));

    assert_purge_off_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        purge |-> !xfer);

endmodule

// File: tb/sim_ccd_line_sequencer.sv
`timescale 1ns/1ps
module sim_ccd_line_sequencer;

    localparam int CLK_HZ_TB = 2_000_000;
    localparam int H_MIN     = (CLK_HZ_TB + 2_000_000 - 1) / 2_000_000;
    localparam int H_MAX     = CLK_HZ_TB / 200_000;
    localparam int XH        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] div_half = '0;
    logic [12:0] line_len = '0;
    logic        purge_en = 1'b0;
    logic [12:0] purge_dly = '0;
    logic        pix_clk, xfer, purge, line_start, elem_valid;
    logic [12:0] elem_idx;
    logic [1:0]  elem_seg;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccd_line_sequencer #(.CLK_HZ(CLK_HZ_TB), .XFER_HALVES(XH)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .div_half(div_half),
        .line_len(line_len), .purge_en(purge_en), .purge_dly(purge_dly),
        .pix_clk(pix_clk), .xfer(xfer), .purge(purge), .line_start(line_start),
        .elem_valid(elem_valid), .elem_idx(elem_idx), .elem_seg(elem_seg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int seg_of(input int k);
        if (k < 24)   return 0;
        if (k < 54)   return 1;
        if (k < 56)   return 0;
        if (k < 3056) return 2;
        return 3;
    endfunction

    // monitor state
    bit pp = 1'b1, pr = 1'b0, started = 1'b0, have_line = 1'b0, stopped = 1'b0;
    int falls = 0, last_falls = 0, cyc = 0, xcyc = 0, lines = 0;
    int e_len = 3100, e_half = 1, e_dly = 0;
    bit e_arm = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit rp = pix_clk && !pp;
            automatic bit fp = !pix_clk && pp;
            automatic bit rr = xfer && !pr;
            automatic bit fr = !xfer && pr;
            automatic bit ev;
            automatic bit es;
            cyc++;
            // R7 line_start strobe
            if (line_start || rr) chk(line_start == rr, "R7 line_start", line_start, rr);
            // R6 sampling strobe
            ev = rp && started;
            if (elem_valid || ev) chk(elem_valid == ev, "R6 elem_valid", elem_valid, ev);
            // R1 pixel half-period
            if ((rp || fp) && started) begin
                chk(cyc == e_half, "R1 half period", cyc, e_half);
                cyc = 0;
            end
            if (rp && started && falls == e_len && !xfer) stopped = 1'b1;
            if (rr) begin
                if (have_line) chk(falls == e_len, "R3 pulses per line", falls, e_len);
                last_falls = falls;
                e_len  = (line_len < 3100) ? 3100 : int'(line_len);
                e_half = (div_half < H_MIN) ? H_MIN : (div_half > H_MAX) ? H_MAX : int'(div_half);
                e_arm  = purge_en;
                e_dly  = purge_dly;
                falls = 0; started = 1'b0; have_line = 1'b1; xcyc = 0; stopped = 1'b0;
                lines++;
            end
            if (xfer) begin
                xcyc++;
                if (!pix_clk) chk(1'b0, "R2 pix held under gate", pix_clk, 1);
            end
            if (fr) begin
                chk(xcyc == XH * e_half, "R2 gate width", xcyc, XH * e_half);
                cyc = 0;
            end
            if (fp) begin
                if (!started) begin
                    chk(cyc == e_half, "R2 first fall delay", cyc, e_half);
                    cyc = 0;
                end
                started = 1'b1;
                chk(int'(elem_idx) == falls, "R4 element index", elem_idx, falls);
                chk(int'(elem_seg) == seg_of(falls), "R5 segment tag", elem_seg, seg_of(falls));
                falls++;
            end
            // R8 purge window
            es = e_arm && started && !(falls == e_len && pix_clk) && (falls - 1 == e_dly);
            if (purge || es) chk(purge == es, "R8 purge pulse", purge, es);
            pp = pix_clk;
            pr = xfer;
        end
    end

    task automatic wait_lines(input int n);
        while (lines < n) @(negedge clk);
    endtask

    task automatic wait_stop();
        while (!stopped) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(pix_clk == 1'b1, "R9 reset pix_clk", pix_clk, 1);
        chk(xfer == 1'b0, "R9 reset xfer", xfer, 0);
        chk(purge == 1'b0 && line_start == 1'b0 && elem_valid == 1'b0, "R9 reset strobes", purge, 0);

        // line 1: low clamps, purge off with in-range delay
        div_half = 16'd0; line_len = 13'd0; purge_en = 1'b0; purge_dly = 13'd5;
        run = 1'b1;
        repeat (1000) @(negedge clk);
        // mid-line change, must only affect line 2 (R10)
        div_half = 16'd2; line_len = 13'd3120; purge_en = 1'b1; purge_dly = 13'd3058;
        wait_lines(2);
        chk(last_falls == 3100, "R10 line 1 ignored mid-line change", last_falls, 3100);
        repeat (1000) @(negedge clk);
        // line 3: high clamp, short length clamps up, purge on element 0
        div_half = 16'd50; line_len = 13'd10; purge_dly = 13'd0;
        wait_lines(3);
        chk(last_falls == 3120, "R3 line 2 length", last_falls, 3120);
        repeat (100) @(negedge clk);
        run = 1'b0;
        wait_stop();
        repeat (300) @(negedge clk);
        // R9 idle after stop
        chk(falls == 3100, "R9 no pulses after stop", falls, 3100);
        chk(pix_clk == 1'b1 && xfer == 1'b0, "R9 idle levels", {pix_clk, xfer}, 2);
        chk(lines == 3, "R9 no new line while stopped", lines, 3);

        // line 4: restart from idle, purge on last element
        div_half = 16'd1; line_len = 13'd3100; purge_en = 1'b1; purge_dly = 13'd3099;
        run = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(xfer == 1'b1, "R9 immediate start", xfer, 1);
        wait_lines(4);
        repeat (10) @(negedge clk);
        run = 1'b0;
        wait_stop();
        repeat (50) @(negedge clk);
        chk(falls == 3100 && xfer == 1'b0, "R3 last line length", falls, 3100);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule